// File: doc/BRIEF.md
# Continuation-Flagged Instruction Byte Unpacker

This block sits between an instruction byte stream and a decoder that wants fixed-width words. Each incoming byte carries a flag in its top bit that says whether another byte of the same instruction follows, plus seven bits of payload. The unpacker stacks the payload groups from least significant upward. When a byte with a clear flag arrives, it presents the gathered word with every missing high group filled with zeros. Short encodings therefore stand for instructions whose upper fields are zero. A one-byte instruction and a 13-bit two-register form both fit without padding bytes.

The word is offered with a count of the bytes it took, on a valid/ready handshake. Bytes are taken on their own valid/ready handshake, and input is stalled while a finished word waits. An encoding that is still asking for more bytes when the word is already full is treated as malformed. Its remaining bytes are swallowed up to the next terminator, and a single error word is then reported.

Top module: `vlbyte_unpack`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Payload bits [6:0] of the k-th byte of an instruction (k counted from 0) land in bits [7k+6:7k] of out_word.
- R3: Bit 7 of a byte set to 1 means another byte of the same instruction follows. Bit 7 cleared ends the instruction, and out_valid rises in the cycle after that byte is taken.
- R4: Word bits above the last supplied group are zero, including after a longer preceding instruction.
- R5: out_len equals the number of bytes the instruction took, from 1 up to MAX_GROUPS.
- R6: While out_valid is 1 and out_ready is 0, out_word, out_len and out_err hold steady and in_ready is 0. A byte offered in that time is taken only after the word is accepted.
- R7: If byte number MAX_GROUPS of an instruction has bit 7 set, no word is produced and the following bytes are dropped up to and including one with bit 7 clear. A single word with out_err=1, out_word=0 and out_len=MAX_GROUPS is then presented.
- R8: The byte after an error terminator starts a fresh instruction that decodes normally with out_err=0.
- R9: A lone byte with bit 7 clear, including 0x00, yields a one-byte word equal to its payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Bit 7 continuation flag, bits 6:0 payload |
| in_valid | input | 1 | in_byte is offered |
| in_ready | output | 1 | Byte is taken on this edge when in_valid is 1 |
| out_word | output | MAX_GROUPS*GROUP_W | Unpacked, zero-extended instruction word |
| out_len | output | $clog2(MAX_GROUPS+1) | Bytes consumed |
| out_err | output | 1 | Word reports an over-long encoding |
| out_valid | output | 1 | Word is offered |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
The bench builds the unpacker with MAX_GROUPS=4 and GROUP_W=7, which gives a 28-bit word and a 3-bit count. This puts both the full-width word and the overflow boundary within four bytes. With that setting the bench can reach an all-ones full word, the zero fill after it, a stalled output with a byte waiting behind it, and a malformed run that is discarded across several bytes, followed by a clean recovery.

// File: rtl/vlbyte_unpack.sv
module vlbyte_unpack #(
  parameter int MAX_GROUPS = 6,
  parameter int GROUP_W    = 7
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [GROUP_W:0]                       in_byte,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  output logic [MAX_GROUPS*GROUP_W-1:0]          out_word,
  output logic [$clog2(MAX_GROUPS+1)-1:0]        out_len,
  output logic                                   out_err,
  output logic                                   out_valid,
  input  logic                                   out_ready
);
  localparam int WORD_W = MAX_GROUPS * GROUP_W;
  localparam int CNT_W  = $clog2(MAX_GROUPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_GROUPS - 1);

  logic [WORD_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;
  logic              dropping;
  logic              take;
  logic              more;
  logic [WORD_W-1:0] merged;

  assign in_ready = !out_valid;
  assign take     = in_valid && in_ready;
  assign more     = in_byte[GROUP_W];
  assign merged   = acc | (WORD_W'(in_byte[GROUP_W-1:0]) << (int'(cnt) * GROUP_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      dropping  <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_len   <= '0;
      out_err   <= 1'b0;
    end else begin
      if (out_valid && out_ready)
        out_valid <= 1'b0;
      if (take) begin
        if (dropping) begin
          if (!more) begin
            dropping  <= 1'b0;
            out_valid <= 1'b1;
            out_word  <= '0;
            out_len   <= CNT_W'(MAX_GROUPS);
            out_err   <= 1'b1;
          end
        end else if (!more) begin
          out_valid <= 1'b1;
          out_word  <= merged;
          out_len   <= cnt + 1'b1;
          out_err   <= 1'b0;
          acc       <= '0;
          cnt       <= '0;
        end else if (cnt == LAST) begin
          dropping <= 1'b1;
          acc      <= '0;
          cnt      <= '0;
        end else begin
          acc <= merged;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module vlbyte_unpack_chk #(
  parameter int MAX_GROUPS = 6,
  parameter int GROUP_W    = 7
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                in_ready,
  input logic [MAX_GROUPS*GROUP_W-1:0]       out_word,
  input logic [$clog2(MAX_GROUPS+1)-1:0]     out_len,
  input logic                                out_err,
  input logic                                out_valid,
  input logic                                out_ready
);
  assert_stall_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_len) && $stable(out_err)));

  assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != 0 && int'(out_len) <= MAX_GROUPS));

  assert_err_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_word == '0 && int'(out_len) == MAX_GROUPS));

  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> ((out_word >> (int'(out_len) * GROUP_W)) == '0));
endmodule

bind vlbyte_unpack vlbyte_unpack_chk #(.MAX_GROUPS(MAX_GROUPS), .GROUP_W(GROUP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_word(out_word),
  .out_len(out_len), .out_err(out_err), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/vlbyte_unpack_tb.sv
module vlbyte_unpack_tb;
  localparam int MG = 4;
  localparam int GW = 7;
  localparam int WW = MG * GW;
  localparam int CW = $clog2(MG + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [GW:0]   in_byte = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [WW-1:0] out_word;
  logic [CW-1:0] out_len;
  logic          out_err;
  logic          out_valid;
  logic          out_ready = 1'b0;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vlbyte_unpack #(.MAX_GROUPS(MG), .GROUP_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
    .out_word(out_word), .out_len(out_len), .out_err(out_err), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    bit acc;
    in_byte = b;
    in_valid = 1'b1;
    forever begin
      acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic expect_word(input longint w, input int len, input bit err, input string tag);
    int guard = 0;
    while (!out_valid && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk(out_valid == 1'b1, {tag, " out_valid"}, out_valid, 1);
    chk(out_word == WW'(w), {tag, " out_word"}, out_word, w);
    chk(out_len == CW'(len), {tag, " out_len"}, out_len, len);
    chk(out_err == err, {tag, " out_err"}, out_err, err);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_single;
    send(8'h00);
    chk(out_valid == 1'b1, "R3 valid one cycle after terminator", out_valid, 1);
    expect_word(0, 1, 0, "R9 zero byte");
    send(8'h55);
    expect_word(64'h55, 1, 0, "R9 single byte");
  endtask

  task automatic t_two;
    send(8'h85);
    chk(out_valid == 1'b0, "R3 no word while continuing", out_valid, 0);
    send(8'h3A);
    expect_word(64'h1D05, 2, 0, "R2 two bytes");
  endtask

  task automatic t_full;
    send(8'hFF); send(8'hFF); send(8'hFF); send(8'h7F);
    expect_word(64'hFFFFFFF, 4, 0, "R5 full length");
    send(8'h83); send(8'h92); send(8'h21);
    expect_word(64'h3 | (64'h12 << 7) | (64'h21 << 14), 3, 0, "R2 three groups");
  endtask

  task automatic t_zero_fill;
    send(8'hFF); send(8'hFF); send(8'hFF); send(8'h7F);
    expect_word(64'hFFFFFFF, 4, 0, "R5 full again");
    send(8'h81); send(8'h00);
    expect_word(64'h1, 2, 0, "R4 upper groups zero");
  endtask

  task automatic t_hold;
    logic [WW-1:0] w0;
    send(8'h12);
    w0 = out_word;
    in_byte = 8'h33;
    in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_word == w0 && out_len == 1, "R6 word held", out_word, w0);
      chk(in_ready == 1'b0, "R6 in_ready low", in_ready, 0);
    end
    chk(out_word == 'h12, "R6 held value", out_word, 'h12);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    expect_word(64'h33, 1, 0, "R6 queued byte");
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 no duplicate", out_valid, 0);
  endtask

  task automatic t_overflow;
    send(8'h81); send(8'h82); send(8'h83); send(8'h84);
    chk(out_valid == 1'b0, "R7 no word at overflow", out_valid, 0);
    send(8'h90);
    chk(out_valid == 1'b0, "R7 dropped byte", out_valid, 0);
    send(8'h11);
    expect_word(0, MG, 1, "R7 error word");
  endtask

  task automatic t_recover;
    send(8'h05);
    expect_word(64'h5, 1, 0, "R8 recovery");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_two;
    t_full;
    t_zero_fill;
    t_hold;
    t_overflow;
    t_recover;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule